// File: doc/BRIEF.md
# Serial Frequency Word Loader

This block takes a tuning frequency word that arrives one bit per clock on a serial data wire and assembles it into a 32-bit holding register. A downstream oscillator reads that register. A separate sync wire marks the start of each word. It is held high for a single clock, one cycle before the most significant bit. A 2-bit width field selects how many bits make up a word: 8, 16, 24 or 32.

When the last bit of a word has been shifted in, the word is moved into the holding register. Shorter words are placed in the most significant bits and the unused low bits are cleared. A one-cycle valid pulse marks each update. Words may follow one another with no idle cycle between them. A new sync pulse in the middle of a word abandons the partial word and starts again. The whole block runs on a single clock.

Top module: `serial_freq_loader`

## Requirements
- R1: While reset is active and after it is released, `holdWord` is zero and `loadValid` is low until the first word completes.
- R2: The width code on `widthSel` selects the word length: 2'b00 = 8 bits, 2'b01 = 16, 2'b10 = 24, 2'b11 = 32.
- R3: A word starts with `serSync` sampled high on one rising edge. The value on `serData` in that same cycle is not part of the word. The word's bits are sampled MSB first on the following rising edges.
- R4: The sync pulse arms a count of the selected length. The word is written to `holdWord` on the edge that samples its last bit, so `loadValid` is high during the cycle after that edge.
- R5: A word of W bits shorter than 32 is written into `holdWord[31:32-W]`, and `holdWord[31-W:0]` is zero.
- R6: `loadValid` is high for exactly one cycle per completed word. `holdWord` keeps its value between completed words.
- R7: A sync pulse sampled on the same edge as the last bit of a word completes that word and also starts the next one, so words can follow with no gap.
- R8: A sync pulse sampled while a word is still incomplete discards the partial word, produces no `loadValid`, and restarts reception.
- R9: The width code is captured at the sync pulse. A change of `widthSel` in the middle of a word has no effect on that word.
- R10: Bits on `serData` while no word is in progress change neither `holdWord` nor `loadValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| widthSel | input | 2 | Serial word length code, captured at sync |
| serData | input | 1 | Serial data bit, MSB first |
| serSync | input | 1 | One-cycle start strobe, one cycle ahead of the first bit |
| holdWord | output | 32 | Left-justified frequency word for the oscillator |
| loadValid | output | 1 | One-cycle pulse when `holdWord` is updated |

## Verification
A table of words covers all four length codes. The data patterns are chosen so that a misplaced bit shows up. Patterns with ones at the top and bottom of each length show whether the word is justified to the correct position. Patterns with set bits above the selected length show whether the cleared low bits and the dropped high bits are handled correctly. Directed sequences cover the following:
- a set bit during the sync cycle, which separates an off-by-one start from a correct one;
- a sync pulse in the middle of a word, which separates restart from completion;
- a width change after sync, which separates captured from live width;
- a sync on the last bit, which separates true back-to-back reception from a one-cycle gap.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

  localparam int WIDTH_CODE_W = 2;

  // Strobes from the control path to the datapath
  typedef struct packed {
    logic                    clearShift;  // new word begins
    logic                    shiftEn;     // take one bit this edge
    logic                    transfer;    // last bit: move word to holding register
    logic [WIDTH_CODE_W-1:0] widthCode;   // width captured at sync
  } strobe_t;

endpackage

// File: rtl/sfl_ctrl.sv
module sfl_ctrl #(
  parameter int HOLD_W = 32
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [sfl_pkg::WIDTH_CODE_W-1:0]    widthSel,
  input  logic                                serSync,
  output sfl_pkg::strobe_t                    strb
);
  localparam int STEP  = HOLD_W / 4;
  localparam int CNT_W = $clog2(HOLD_W + 1);

  logic [CNT_W-1:0]                      bitsLeft;
  logic [sfl_pkg::WIDTH_CODE_W-1:0]      widthQ;
  logic                                  busy;
  logic                                  lastBit;

  function automatic logic [CNT_W-1:0] wordBits(input logic [sfl_pkg::WIDTH_CODE_W-1:0] code);
    wordBits = CNT_W'((int'(code) + 1) * STEP);
  endfunction

  assign busy    = (bitsLeft != '0);
  assign lastBit = (bitsLeft == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitsLeft <= '0;
      widthQ   <= '0;
    end else if (serSync) begin
      bitsLeft <= wordBits(widthSel);
      widthQ   <= widthSel;
    end else if (busy) begin
      bitsLeft <= bitsLeft - CNT_W'(1);
    end
  end

  always_comb begin
    strb.clearShift = serSync;
    strb.shiftEn    = busy;
    strb.transfer   = lastBit;
    strb.widthCode  = widthQ;
  end

endmodule

// File: rtl/sfl_datapath.sv
module sfl_datapath #(
  parameter int HOLD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serData,
  input  sfl_pkg::strobe_t  strb,
  output logic [HOLD_W-1:0] holdWord,
  output logic              loadValid
);
  localparam int STEP = HOLD_W / 4;

  logic [HOLD_W-1:0] shiftReg;
  logic [HOLD_W-1:0] shifted;
  logic [HOLD_W-1:0] justified;
  int                padBits;

  always_comb begin
    shifted   = {shiftReg[HOLD_W-2:0], serData};
    padBits   = HOLD_W - (int'(strb.widthCode) + 1) * STEP;
    justified = shifted << padBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      holdWord  <= '0;
      loadValid <= 1'b0;
    end else begin
      if (strb.clearShift)   shiftReg <= '0;
      else if (strb.shiftEn) shiftReg <= shifted;
      if (strb.transfer) holdWord <= justified;
      loadValid <= strb.transfer;
    end
  end

endmodule

// File: rtl/serial_freq_loader.sv
module serial_freq_loader #(
  parameter int HOLD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        widthSel,
  input  logic              serData,
  input  logic              serSync,
  output logic [HOLD_W-1:0] holdWord,
  output logic              loadValid
);
  sfl_pkg::strobe_t strb;

  sfl_ctrl #(.HOLD_W(HOLD_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .widthSel (widthSel),
    .serSync  (serSync),
    .strb     (strb)
  );

  sfl_datapath #(.HOLD_W(HOLD_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .serData   (serData),
    .strb      (strb),
    .holdWord  (holdWord),
    .loadValid (loadValid)
  );

endmodule

// File: rtl/sfl_checker.sv
module sfl_checker #(
  parameter int HOLD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              serSync,
  input sfl_pkg::strobe_t  strb,
  input logic [HOLD_W-1:0] holdWord,
  input logic              loadValid
);
  localparam int STEP = HOLD_W / 4;

  logic [1:0] lastWidth;

  always_ff @(posedge clk) begin
    if (!rstN) lastWidth <= 2'b11;
    else if (strb.transfer) lastWidth <= strb.widthCode;
  end

  function automatic logic [HOLD_W-1:0] lowMask(input logic [1:0] code);
    lowMask = ({HOLD_W{1'b1}}) >> ((int'(code) + 1) * STEP);
  endfunction

  assert_load_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |=> !loadValid);

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    !loadValid |-> $stable(holdWord));

  assert_low_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |-> ((holdWord & lowMask(lastWidth)) == '0));

  assert_sync_arms_R4: assert property (@(posedge clk) disable iff (!rstN)
    serSync |=> strb.shiftEn);

endmodule

bind serial_freq_loader sfl_checker #(.HOLD_W(HOLD_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .serSync   (serSync),
  .strb      (strb),
  .holdWord  (holdWord),
  .loadValid (loadValid)
);

// File: tb/serial_freq_loader_tb_top.sv
`timescale 1ns/1ps
module serial_freq_loader_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  widthSel = 2'b00;
  logic        serData = 1'b0;
  logic        serSync = 1'b0;
  logic [31:0] holdWord;
  logic        loadValid;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  serial_freq_loader dut_i (
    .clk(clk), .rstN(rstN), .widthSel(widthSel), .serData(serData),
    .serSync(serSync), .holdWord(holdWord), .loadValid(loadValid)
  );

  // {width code, raw data}; only the low W bits of data are sent
  localparam logic [33:0] VEC [8] = '{
    {2'b00, 32'h0000_00A5},
    {2'b00, 32'hFFFF_FF81},
    {2'b01, 32'h0000_8001},
    {2'b01, 32'h1234_C3A5},
    {2'b10, 32'h0080_0001},
    {2'b10, 32'hAB5A_F00F},
    {2'b11, 32'h8000_0001},
    {2'b11, 32'hDEAD_BEEF}
  };

  function automatic int bitsOf(input logic [1:0] code);
    return (int'(code) + 1) * 8;
  endfunction

  function automatic logic [31:0] expWord(input logic [1:0] code, input logic [31:0] data);
    return data << (32 - bitsOf(code));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic d);
    @(negedge clk);
    serSync = s;
    serData = d;
  endtask

  task automatic sendBits(input logic [1:0] code, input logic [31:0] data);
    for (int i = bitsOf(code) - 1; i >= 0; i--) step(1'b0, data[i]);
  endtask

  initial begin
    logic [31:0] held;
    logic [1:0]  code;
    logic [31:0] data;
    logic        sawValid;

    repeat (3) @(negedge clk);
    check("R1 reset holdWord", holdWord, 32'h0);
    check("R1 reset loadValid", {31'h0, loadValid}, 32'h0);
    rstN = 1'b1;
    step(1'b0, 1'b0);
    check("R1 after release loadValid", {31'h0, loadValid}, 32'h0);

    // Table walk: R2, R3, R4, R5, R6
    for (int v = 0; v < 8; v++) begin
      code = VEC[v][33:32];
      data = VEC[v][31:0];
      @(negedge clk);
      widthSel = code;
      serSync  = 1'b1;
      serData  = 1'b0;
      sendBits(code, data);
      step(1'b0, 1'b0);
      check("R4 loadValid after last bit", {31'h0, loadValid}, 32'h1);
      check("R2 R5 justified word", holdWord, expWord(code, data));
      step(1'b0, 1'b1);
      check("R6 loadValid single cycle", {31'h0, loadValid}, 32'h0);
      check("R6 holdWord retained", holdWord, expWord(code, data));
    end

    // R10: idle data ignored
    held = holdWord;
    sawValid = 1'b0;
    for (int i = 0; i < 12; i++) begin
      step(1'b0, i[0]);
      if (loadValid) sawValid = 1'b1;
    end
    check("R10 idle no loadValid", {31'h0, sawValid}, 32'h0);
    check("R10 idle holdWord unchanged", holdWord, held);

    // R8: restart mid-word discards partial
    @(negedge clk);
    widthSel = 2'b01;
    serSync = 1'b1; serData = 1'b1;
    sawValid = 1'b0;
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 1'b1);
      if (loadValid) sawValid = 1'b1;
    end
    step(1'b1, 1'b1);
    if (loadValid) sawValid = 1'b1;
    sendBits(2'b01, 32'h0000_3C5A);
    step(1'b0, 1'b0);
    check("R8 no loadValid for partial", {31'h0, sawValid}, 32'h0);
    check("R8 restarted word", holdWord, 32'h3C5A_0000);

    // R9 and R3: width captured at sync; bit during sync cycle ignored
    @(negedge clk);
    widthSel = 2'b00;
    serSync = 1'b1; serData = 1'b1;
    step(1'b0, 1'b0);
    widthSel = 2'b11;
    for (int i = 6; i >= 0; i--) step(1'b0, i[0]);
    step(1'b0, 1'b0);
    check("R9 width held, loadValid at 8 bits", {31'h0, loadValid}, 32'h1);
    check("R3 R9 sync-cycle bit excluded", holdWord, 32'h2A00_0000);

    // R7: back-to-back 8-bit words, sync with last bit
    @(negedge clk);
    widthSel = 2'b00;
    serSync = 1'b1; serData = 1'b0;
    for (int i = 7; i >= 1; i--) step(1'b0, 1'(8'h81 >> i));
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);  // first bit of 0x7E
    check("R7 first word loadValid", {31'h0, loadValid}, 32'h1);
    check("R7 first word value", holdWord, 32'h8100_0000);
    for (int i = 6; i >= 0; i--) step(1'b0, 1'(8'h7E >> i));
    step(1'b0, 1'b0);
    check("R7 second word loadValid", {31'h0, loadValid}, 32'h1);
    check("R7 second word value", holdWord, 32'h7E00_0000);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule